// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives the active-low system reset of a processor subsystem from three digital inputs: a supply-good flag that an external comparator produces and that is already synchronous to the clock, an active-low manual reset request, and a watchdog kick line that the processor toggles. Reset is held while the supply flag is low or manual reset is requested. It is released only once every condition has stayed good for a fixed delay. The supply flag gates the reset output directly, so a supply drop pulls reset low in the same cycle, with no clock edge in between.

Once reset is released, a watchdog counter runs. Each change on the kick line restarts it, whether the line rises or falls. If the counter reaches its time-out, the block drives a reset pulse that lasts the full release delay. The watchdog then re-arms from zero. The manual reset and kick lines each pass through a two-flop synchronizer before they are used. The delay and the time-out are parameters counted in clock ticks.

The controller is a four-state machine:
- **ST_HOLD**: conditions are bad and reset is low.
- **ST_DELAY**: the release delay is being counted.
- **ST_RUN**: reset is released and the watchdog is armed.
- **ST_WDRST**: a reset pulse caused by the watchdog.

Its transitions are:
- **HOLD→DELAY**: all conditions are good.
- **DELAY→RUN** and **WDRST→RUN**: the delay has completed.
- **RUN→WDRST**: the watchdog has timed out.
- **any→HOLD**: the supply drops or manual reset is asserted.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `arst_n` is low, `rst_out_n` is 0. Whenever `supply_ok` is 0, `rst_out_n` is 0 in that same cycle, and the controller stays in hold.
- R2: After `supply_ok` rises while manual reset is released, `rst_out_n` goes high on exactly the (DELAY_TICKS+1)-th rising clock edge. It is still low after DELAY_TICKS edges.
- R3: If `supply_ok` drops during the release delay, the delay restarts. `rst_out_n` goes high on the (DELAY_TICKS+1)-th edge after the supply returns.
- R4: Driving `mr_n` to 0 pulls `rst_out_n` to 0 after the second rising edge, following the two-flop synchronizer. `rst_out_n` is still high after the first edge.
- R5: After `mr_n` returns to 1 with the supply good, `rst_out_n` goes high on the (DELAY_TICKS+3)-th rising edge.
- R6: With no change on `wdi`, `rst_out_n` falls on the WDOG_TICKS-th rising edge after reset was released.
- R7: A 0→1 change on `wdi` restarts the watchdog. The next time-out falls on edge WDOG_TICKS+3 after the change. A kick period of WDOG_TICKS/2 keeps reset released.
- R8: A 1→0 change on `wdi` restarts the watchdog in the same way as a rising change, with the same timing.
- R9: A watchdog time-out holds `rst_out_n` low for exactly DELAY_TICKS cycles. The watchdog then restarts from zero, because it is held cleared whenever reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Synchronized supply-above-threshold flag |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog kick; either edge restarts the time-out |
| rst_out_n | output | 1 | System reset, active low |

## Verification
The release delay is exercised in three ways: a clean supply rise, a one-cycle supply glitch in the middle of the delay, and a manual reset release. The three differ in the extra synchronizer latency and in whether the delay counter restarts. The watchdog is tried with no kicks, with a single rising kick, with a single falling kick and with periodic kicks. Each is sampled on the exact edge where the time-out must or must not occur, which separates edge-sensitive from level-sensitive kick detection and counting from reset release from counting during reset. The watchdog reset pulse is measured cycle-exact to show that the full delay is applied and that the counter re-arms afterwards.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2,
        ST_WDRST = 2'd3
    } sup_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                stage1 <= RST_VAL[i];
                stage2 <= RST_VAL[i];
            end else begin
                stage1 <= d_async[i];
                stage2 <= stage1;
            end
        end
        assign q_sync[i] = stage2;
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WDOG_TICKS = 200_000_000,
    localparam int CW = $clog2(WDOG_TICKS + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run_i,
    input  logic kick_line_i,
    output logic timeout_o
);
    logic          line_q;
    logic          kick;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) line_q <= 1'b0;
        else         line_q <= kick_line_i;
    end

    assign kick      = line_q ^ kick_line_i;
    assign timeout_o = run_i && (cnt == CW'(WDOG_TICKS - 1));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                          cnt <= '0;
        else if (!run_i || kick || timeout_o) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end

    // R7 / R8: any change on the synchronized line restarts the count
    assert_kick_clears_R7: assert property (@(posedge clk) disable iff (!arst_n)
        kick |=> (cnt == '0));
    // R9: counter stays cleared while reset is asserted
    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !run_i |=> (cnt == '0));
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!arst_n)
        cnt < CW'(WDOG_TICKS));
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
#(
    parameter int DELAY_TICKS = 25_000_000,
    localparam int DW = $clog2(DELAY_TICKS + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic mr_ok,
    input  logic wd_timeout,
    output logic wd_run,
    output logic rst_out_n
);
    sup_state_e    state, nxt;
    logic [DW-1:0] dly_cnt;
    logic          bad;
    logic          dly_done;

    assign bad      = !supply_ok || !mr_ok;
    assign dly_done = (dly_cnt == DW'(DELAY_TICKS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:  if (!bad) nxt = ST_DELAY;
            ST_DELAY: if (bad) nxt = ST_HOLD; else if (dly_done) nxt = ST_RUN;
            ST_RUN:   if (bad) nxt = ST_HOLD; else if (wd_timeout) nxt = ST_WDRST;
            ST_WDRST: if (bad) nxt = ST_HOLD; else if (dly_done) nxt = ST_RUN;
            default:  nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_HOLD;
        else         state <= nxt;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                                     dly_cnt <= '0;
        else if (nxt != state)                           dly_cnt <= '0;
        else if (state == ST_DELAY || state == ST_WDRST) dly_cnt <= dly_cnt + 1'b1;
        else                                             dly_cnt <= '0;
    end

    always_comb begin
        wd_run    = (state == ST_RUN);
        rst_out_n = (state == ST_RUN) && !bad;
    end

    assert_supply_low_hold_R1: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> (state == ST_HOLD));
    // R2 / R9: every release follows a full delay count
    assert_full_delay_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(state == ST_RUN) |-> ($past(dly_cnt) == DW'(DELAY_TICKS - 1)));
    assert_manual_hold_R4: assert property (@(posedge clk) disable iff (!arst_n)
        !mr_ok |=> (state == ST_HOLD));
    assert_wdog_trip_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RUN && wd_timeout && !bad) |=> (state == ST_WDRST));
    assert_delay_bound_R3: assert property (@(posedge clk) disable iff (!arst_n)
        dly_cnt < DW'(DELAY_TICKS));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int DELAY_TICKS = 25_000_000,
    parameter int WDOG_TICKS  = 200_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic mr_n,
    input  logic wdi,
    output logic rst_out_n
);
    logic [1:0] synced;
    logic       wd_run;
    logic       wd_timeout;

    // bit 0: manual reset (idle 1), bit 1: kick line (idle 0)
    sup_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .d_async ({wdi, mr_n}),
        .q_sync  (synced)
    );

    sup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk         (clk),
        .arst_n      (arst_n),
        .run_i       (wd_run),
        .kick_line_i (synced[1]),
        .timeout_o   (wd_timeout)
    );

    sup_fsm #(.DELAY_TICKS(DELAY_TICKS)) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .supply_ok  (supply_ok),
        .mr_ok      (synced[0]),
        .wd_timeout (wd_timeout),
        .wd_run     (wd_run),
        .rst_out_n  (rst_out_n)
    );
endmodule

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;
    localparam int D = 20;
    localparam int W = 60;

    logic clk = 1'b0;
    logic arst_n, supply_ok, mr_n, wdi, rst_out_n;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    sup_reset_ctrl #(.DELAY_TICKS(D), .WDOG_TICKS(W)) u_sup_reset_ctrl (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok),
        .mr_n(mr_n), .wdi(wdi), .rst_out_n(rst_out_n)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp);
        n_checks++;
        if (rst_out_n !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_out_n=%b expected %b at %0t", req, rst_out_n, exp, $time);
        end
    endtask

    task automatic t_reset_state();
        arst_n = 1'b0; supply_ok = 1'b0; mr_n = 1'b1; wdi = 1'b0;
        edges(3);
        chk("R1", 1'b0);
        arst_n = 1'b1;
        edges(5);
        chk("R1", 1'b0);
    endtask

    task automatic t_power_up();
        supply_ok = 1'b1;
        edges(D);     chk("R2", 1'b0);
        edges(1);     chk("R2", 1'b1);
    endtask

    task automatic t_supply_drop();
        edges(3);
        supply_ok = 1'b0;
        #0.5;         chk("R1", 1'b0);
        edges(4);     chk("R1", 1'b0);
    endtask

    task automatic t_glitch_restart();
        supply_ok = 1'b1;
        edges(D / 2); chk("R3", 1'b0);
        supply_ok = 1'b0;
        edges(1);     chk("R3", 1'b0);
        supply_ok = 1'b1;
        edges(D);     chk("R3", 1'b0);
        edges(1);     chk("R3", 1'b1);
    endtask

    task automatic t_manual();
        mr_n = 1'b0;
        edges(1);     chk("R4", 1'b1);
        edges(1);     chk("R4", 1'b0);
        edges(5);     chk("R4", 1'b0);
        mr_n = 1'b1;
        edges(D + 2); chk("R5", 1'b0);
        edges(1);     chk("R5", 1'b1);
    endtask

    task automatic t_no_kick();
        edges(W - 1); chk("R6", 1'b1);
        edges(1);     chk("R6", 1'b0);
    endtask

    task automatic t_wd_pulse();
        edges(D - 1); chk("R9", 1'b0);
        edges(1);     chk("R9", 1'b1);
    endtask

    task automatic t_kick(input string req, input logic lvl);
        edges(W - 10);
        wdi = lvl;
        edges(W + 2); chk(req, 1'b1);
        edges(1);     chk(req, 1'b0);
    endtask

    task automatic t_periodic();
        for (int i = 0; i < 8; i++) begin
            edges(W / 2);
            wdi = ~wdi;
            chk("R7", 1'b1);
        end
    endtask

    initial begin
        t_reset_state();
        t_power_up();
        t_supply_drop();
        t_glitch_restart();
        t_manual();
        t_no_kick();
        t_wd_pulse();
        t_kick("R7", 1'b1);
        t_wd_pulse();
        t_kick("R8", 1'b0);
        t_wd_pulse();
        t_periodic();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: bench did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule